// File: doc/BRIEF.md
# Pixel Configuration Chain

The block holds the static setup of a pixel readout array and is loaded bit by bit over a serial programming port. Each pixel cell owns two configuration bits. The cell-off bit silences a noisy cell when it is 1. The pulse-enable bit, when it is 1, routes the analog calibration pulse to that cell's input. All cell-off bits form one long shift chain, and all pulse-enable bits form a second chain that is fully independent. Both chains wind through the array column by column, reversing direction in alternate columns. A third chain holds a bank of 8-bit bias codes for the analog converters, where code 255 means full scale.

A two-bit select input picks the chain that moves when the shift enable is high. The bit that leaves the tail of the selected chain is shown on the serial output, so the host can read the stored contents back and look for upsets. The recirculate option feeds the tail back into the head. Shifting a chain by its full length with this option set leaves the contents as they were, so a readback does not destroy them. The parallel pixel and bias outputs come from shadow registers that copy the chains only on a load strobe. Half-shifted data therefore never reaches the array.

Top module: `pix_cfg_chain`

## Requirements
- R1: When rst_ni is asserted (low), every chain bit and every parallel output bit goes to 0: all cells enabled, no cell pulsed, all bias codes 0. sdo_o is then 0.
- R2: sel_i chooses the chain: 0 = cell-off, 1 = pulse-enable, 2 = bias bank, 3 = none. On a clock edge with shift_i high, only the selected chain moves. With sel_i = 3, or with shift_i low, no chain changes.
- R3: A shift moves each chain bit from position k to position k+1. The new bit enters position 0 and is sdi_i. Position LEN-1 is the tail, and sdo_o shows the tail of the selected chain in the same cycle. sdo_o is 0 when sel_i = 3.
- R4: When recirc_i is high during a shift, the bit entering position 0 is the old tail and sdi_i is ignored. A full chain length of such shifts leaves the chain unchanged.
- R5: mask_o, inj_o and dac_o change only on the clock edge at which load_i is high. At that edge they take the chain contents held just before the edge.
- R6: Cell-off chain position k maps to column c = k / N_ROWS with j = k % N_ROWS. The row is r = j when c is even and r = N_ROWS-1-j when c is odd. The bit drives mask_o[c*N_ROWS + r], and 1 disables the cell.
- R7: The pulse-enable chain uses the same serpentine mapping onto inj_o, where 1 lets the cell receive the calibration pulse. It is independent of the cell-off chain.
- R8: Bias-chain position k drives dac_o[k]. Bias register d is dac_o[d*8 +: 8], so the last 8 bits shifted in, with the most significant bit first, form register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Chain select: 0 cell-off, 1 pulse-enable, 2 bias bank, 3 none |
| shift_i | input | 1 | Shift the selected chain by one bit |
| recirc_i | input | 1 | Feed the tail back into the head instead of sdi_i |
| sdi_i | input | 1 | Serial data in |
| load_i | input | 1 | Copy the chains to the parallel outputs |
| sdo_o | output | 1 | Tail bit of the selected chain |
| mask_o | output | N_COLS*N_ROWS | Per-pixel cell-off bits, index column*N_ROWS+row |
| inj_o | output | N_COLS*N_ROWS | Per-pixel pulse-enable bits, same indexing |
| dac_o | output | N_DAC*DAC_W | Bias codes, register d at [d*8 +: 8] |

## Verification
The chains are registered, and each shift takes effect at the edge where shift_i is high. The bench drives every input at the falling edge and reads sdo_o before the next rising edge, so sdo_o always shows the tail as it is before the next shift. The parallel outputs lag load_i by one edge, and the bench compares them at the falling edge that follows the load. Before any load, it also confirms that a long run of shifts has left the parallel outputs untouched.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_INJ  = 2'd1,
    SEL_DAC  = 2'd2,
    SEL_NONE = 2'd3
  } chain_sel_e;
endpackage

// File: rtl/pcc_shift_chain.sv
module pcc_shift_chain #(
  parameter int LEN = 512
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           recirc_i,
  input  logic           sdi_i,
  output logic [LEN-1:0] q_o
);
  logic head_d;
  assign head_d = recirc_i ? q_o[LEN-1] : sdi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[LEN-2:0], head_d};
  end
endmodule

// File: rtl/pcc_serpentine_map.sv
module pcc_serpentine_map #(
  parameter int N_COLS = 16,
  parameter int N_ROWS = 32,
  localparam int NPIX  = N_COLS * N_ROWS
) (
  input  logic [NPIX-1:0] chain_i,
  output logic [NPIX-1:0] pix_o
);
  // even columns run up, odd columns run down
  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int K = c * N_ROWS + (((c % 2) == 1) ? (N_ROWS - 1 - r) : r);
      assign pix_o[c*N_ROWS + r] = chain_i[K];
    end
  end
endmodule

// File: rtl/pcc_shadow_reg.sv
module pcc_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pix_cfg_chain.sv
module pix_cfg_chain #(
  parameter int N_COLS    = 16,
  parameter int N_ROWS    = 32,
  parameter int N_DAC     = 14,
  parameter int DAC_W     = 8,
  localparam int NPIX     = N_COLS * N_ROWS,
  localparam int DAC_BITS = N_DAC * DAC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          sel_i,
  input  logic                shift_i,
  input  logic                recirc_i,
  input  logic                sdi_i,
  input  logic                load_i,
  output logic                sdo_o,
  output logic [NPIX-1:0]     mask_o,
  output logic [NPIX-1:0]     inj_o,
  output logic [DAC_BITS-1:0] dac_o
);
  import pcc_pkg::*;

  chain_sel_e sel;
  assign sel = chain_sel_e'(sel_i);

  logic en_mask, en_inj, en_dac;
  assign en_mask = shift_i && (sel == SEL_MASK);
  assign en_inj  = shift_i && (sel == SEL_INJ);
  assign en_dac  = shift_i && (sel == SEL_DAC);

  logic [NPIX-1:0]     mask_q, inj_q, mask_pix, inj_pix;
  logic [DAC_BITS-1:0] dac_q;

  pcc_shift_chain #(.LEN(NPIX)) u_mask_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_mask),
    .recirc_i(recirc_i), .sdi_i(sdi_i), .q_o(mask_q)
  );
  pcc_shift_chain #(.LEN(NPIX)) u_inj_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_inj),
    .recirc_i(recirc_i), .sdi_i(sdi_i), .q_o(inj_q)
  );
  pcc_shift_chain #(.LEN(DAC_BITS)) u_dac_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_dac),
    .recirc_i(recirc_i), .sdi_i(sdi_i), .q_o(dac_q)
  );

  pcc_serpentine_map #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_mask_map (
    .chain_i(mask_q), .pix_o(mask_pix)
  );
  pcc_serpentine_map #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_inj_map (
    .chain_i(inj_q), .pix_o(inj_pix)
  );

  pcc_shadow_reg #(.W(NPIX)) u_mask_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .d_i(mask_pix), .q_o(mask_o)
  );
  pcc_shadow_reg #(.W(NPIX)) u_inj_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .d_i(inj_pix), .q_o(inj_o)
  );
  pcc_shadow_reg #(.W(DAC_BITS)) u_dac_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .d_i(dac_q), .q_o(dac_o)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: sdo_o = mask_q[NPIX-1];
      SEL_INJ:  sdo_o = inj_q[NPIX-1];
      SEL_DAC:  sdo_o = dac_q[DAC_BITS-1];
      default:  sdo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcc_chain_checker.sv
module pcc_chain_checker #(
  parameter int NPIX     = 512,
  parameter int DAC_BITS = 112
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          sel_i,
  input logic                shift_i,
  input logic                recirc_i,
  input logic                sdi_i,
  input logic                load_i,
  input logic [NPIX-1:0]     mask_o,
  input logic [NPIX-1:0]     inj_o,
  input logic [DAC_BITS-1:0] dac_o,
  input logic [NPIX-1:0]     mask_q,
  input logic [NPIX-1:0]     inj_q,
  input logic [DAC_BITS-1:0] dac_q
);
  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sel_i == 2'd0) |=> $stable(mask_q));

  a_r2_inj_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sel_i == 2'd1) |=> $stable(inj_q));

  a_r2_dac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sel_i == 2'd2) |=> $stable(dac_q));

  a_r3_mask_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && sel_i == 2'd0 && !recirc_i) |=> (mask_q[0] == $past(sdi_i)));

  a_r4_inj_recirc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && sel_i == 2'd1 && recirc_i) |=> (inj_q[0] == $past(inj_q[NPIX-1])));

  a_r5_mask_load_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mask_o));

  a_r5_inj_load_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(inj_o));

  a_r5_dac_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (dac_o == $past(dac_q)));
endmodule

bind pix_cfg_chain pcc_chain_checker #(.NPIX(NPIX), .DAC_BITS(DAC_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .shift_i(shift_i),
  .recirc_i(recirc_i), .sdi_i(sdi_i), .load_i(load_i),
  .mask_o(mask_o), .inj_o(inj_o), .dac_o(dac_o),
  .mask_q(mask_q), .inj_q(inj_q), .dac_q(dac_q)
);

// File: tb/pix_cfg_chain_test.sv
`timescale 1ns/1ps
module pix_cfg_chain_test;
  localparam int NC = 16;
  localparam int NR = 32;
  localparam int NP = NC * NR;
  localparam int DB = 14 * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'd3;
  logic          shift = 1'b0, recirc = 1'b0, sdi = 1'b0, load = 1'b0;
  logic          sdo;
  logic [NP-1:0] mask, inj;
  logic [DB-1:0] dac;

  int checks = 0, errors = 0, cycles = 0;
  logic [NP-1:0] m_mdl = '0, i_mdl = '0, m_sh = '0, i_sh = '0;
  logic [DB-1:0] d_mdl = '0, d_sh = '0;

  pix_cfg_chain uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .shift_i(shift), .recirc_i(recirc),
    .sdi_i(sdi), .load_i(load), .sdo_o(sdo), .mask_o(mask), .inj_o(inj), .dac_o(dac)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [NP-1:0] serp(input logic [NP-1:0] ch);
    logic [NP-1:0] o;
    for (int k = 0; k < NP; k++) begin
      int c = k / NR;
      int j = k % NR;
      int r = (c % 2 == 1) ? NR - 1 - j : j;
      o[c*NR + r] = ch[k];
    end
    return o;
  endfunction

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic b, input logic rc);
    sel = s; sdi = b; recirc = rc; shift = 1'b1;
    @(posedge clk);
    case (s)
      2'd0: m_mdl = {m_mdl[NP-2:0], rc ? m_mdl[NP-1] : b};
      2'd1: i_mdl = {i_mdl[NP-2:0], rc ? i_mdl[NP-1] : b};
      2'd2: d_mdl = {d_mdl[DB-2:0], rc ? d_mdl[DB-1] : b};
      default: ;
    endcase
    @(negedge clk);
    shift = 1'b0;
  endtask

  task automatic do_load();
    load = 1'b1;
    @(posedge clk);
    m_sh = serp(m_mdl); i_sh = serp(i_mdl); d_sh = d_mdl;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic chk_par(input string req);
    chk({req, " mask"}, mask, m_sh);
    chk({req, " inj"}, inj, i_sh);
    chk({req, " dac"}, NP'(dac), NP'(d_sh));
  endtask

  // recirculating readback, comparing each tail bit before its shift
  task automatic readback(input logic [1:0] s, input int len);
    int bad = 0;
    logic exp_b;
    for (int n = 0; n < len; n++) begin
      sel = s; #1;
      exp_b = (s == 2'd0) ? m_mdl[NP-1] : (s == 2'd1) ? i_mdl[NP-1] : d_mdl[DB-1];
      if (sdo !== exp_b) bad++;
      step(s, $urandom % 2, 1'b1);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R3/R4 readback sel %0d: actual %0d mismatches expected 0", s, bad);
    end
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4242);
    logic [NP-1:0] m_snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_par("R1 reset");
    chk("R1 sdo", NP'(sdo), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 directed: single 1 lands at chain tail -> col 15 (odd), row 0
    step(2'd0, 1'b1, 1'b0);
    for (int n = 1; n < NP; n++) step(2'd0, 1'b0, 1'b0);
    chk("R5 no update before load", mask, '0);
    do_load();
    chk("R6 single bit at pixel 480", NP'(mask[480]), NP'(1));
    chk("R6 one bit set", NP'($countones(mask)), NP'(1));

    // R6 random fill; R3 old contents emerge at sdo during shifting
    begin
      int bad = 0;
      for (int n = 0; n < NP; n++) begin
        sel = 2'd0; #1;
        if (sdo !== m_mdl[NP-1]) bad++;
        step(2'd0, $urandom % 2, 1'b0);
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R3 shift-out: actual %0d mismatches expected 0", bad);
      end
    end
    chk("R5 mask held until load", mask, m_sh);
    do_load();
    chk_par("R6 random mask");

    // R7 inject chain, mask untouched (R2)
    for (int n = 0; n < NP; n++) step(2'd1, $urandom % 2, 1'b0);
    do_load();
    chk_par("R7/R2 random inject");

    // R8 bias bank; last 8 bits, MSB first, become register 0
    for (int n = 0; n < DB - 8; n++) step(2'd2, $urandom % 2, 1'b0);
    for (int b = 7; b >= 0; b--) step(2'd2, (8'hA5 >> b) & 1, 1'b0);
    do_load();
    chk("R8 register 0", NP'(dac[7:0]), NP'(8'hA5));
    chk_par("R8 bias bank");

    // R2 sel none and shift low change nothing, sdo 0 with none
    for (int n = 0; n < 40; n++) step(2'd3, $urandom % 2, $urandom % 2);
    sel = 2'd3; #1;
    chk("R3 sdo none", NP'(sdo), '0);
    for (int n = 0; n < 20; n++) begin
      sel = 2'($urandom % 3); sdi = $urandom % 2; shift = 1'b0;
      @(negedge clk);
    end
    do_load();
    chk_par("R2 no shift");

    // R4 full recirculation returns contents unchanged
    m_snap = m_mdl;
    readback(2'd0, NP);
    readback(2'd1, NP);
    readback(2'd2, DB);
    chk("R4 mask chain restored", m_mdl, m_snap);
    do_load();
    chk_par("R4 after recirc");

    // R4 partial recirc then load, mixed with new data (R5 load snapshot)
    for (int n = 0; n < 37; n++) step(2'd1, $urandom % 2, 1'b1);
    for (int n = 0; n < 19; n++) step(2'd0, $urandom % 2, 1'($urandom % 2));
    do_load();
    chk_par("R4/R5 partial");

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    m_mdl = '0; i_mdl = '0; d_mdl = '0; m_sh = '0; i_sh = '0; d_sh = '0;
    @(negedge clk);
    chk_par("R1 reset again");
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule